// File: doc/BRIEF.md
# LED Brightness Register Bank

This block is the register storage that sits behind a serial-bus slave in an LED dimming controller. The bus front end hands it one strobe per received data byte, one strobe per byte it sends back, and single-cycle marks for transaction start and end. The bank holds one 8-bit duty value per LED channel and one mode byte. It drives the channel duty values, an enable for the broadcast address, a select for the slower PWM period and a one-cycle local reset request.

The first byte written after each start is a pointer byte. Its upper three bits choose the stepping behaviour and its lower five bits choose the register. Later bytes are written to, or read from, the chosen register. When stepping is on, the pointer walks through the duty registers and wraps at the last one. The mode byte is guarded. It is taken only through one exact pointer value and only when two check bits carry fixed values. It is staged first and applied at the end of the transaction. If its top bit is set, the whole bank returns to its reset state instead.

Top module: `led_regbank`

## Requirements
- R1: The first byte written after a start is the pointer byte: bits 7..5 form the step option and bits 4..0 the register index. Each later written byte lands in the register the index selects, and duty register k (index k, 0..15) appears on `bright_o[8k+7:8k]`.
- R2: With option 000 the index stays put, so successive data bytes all overwrite the same register.
- R3: With option 001 the index advances by one after each data byte, from 0Fh back to 00h. This works only among the duty registers.
- R4: A data byte is ignored, leaving every register unchanged, when the option is 010..111 or the index is unused (10h..19h, 1Bh..1Fh). A read through such a pointer returns 00h.
- R5: After global reset every duty register is 00h and the mode byte is 03h, so `allcall_en_o` is 1, `slow_pwm_o` is 0 and `local_rst_o` is 0.
- R6: The mode byte can be written only when the pointer byte was exactly 1Ah (index 1Ah, option 000). A pointer of 3Ah leaves the mode unchanged.
- R7: A mode data byte is discarded unless its bit 6 is 0 and its bit 1 is 1.
- R8: An accepted mode byte changes nothing until the stop that ends its transaction. From the cycle after that stop, `allcall_en_o` follows mode bit 0, `slow_pwm_o` follows mode bit 4, and a read at pointer 1Ah returns the full byte.
- R9: If the staged mode byte has bit 7 set, then at the stop every register returns to its reset value instead, and `local_rst_o` is 1 for exactly that one cycle.
- R10: `rd_data_o` shows the register the pointer selects. Each `rd_i` advances the pointer in the same way a data write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low, synchronous |
| start_i | input | 1 | One-cycle mark of a start or repeated start |
| stop_i | input | 1 | One-cycle mark of a stop |
| wr_i | input | 1 | One-cycle strobe: a written byte is on `wr_data_i` |
| wr_data_i | input | 8 | Written byte |
| rd_i | input | 1 | One-cycle strobe: the byte on `rd_data_o` has been sent |
| rd_data_o | output | 8 | Register selected by the pointer |
| bright_o | output | 128 | All sixteen duty registers, channel k in bits 8k+7..8k |
| allcall_en_o | output | 1 | Broadcast address enable (mode bit 0) |
| slow_pwm_o | output | 1 | Slow PWM period select (mode bit 4) |
| local_rst_o | output | 1 | One-cycle pulse when the bank resets itself |

## Verification
The bound checker checks these rules on every cycle. Duty values move only after a write strobe or a local reset. The broadcast enable and slow-PWM select move only in the cycle after a stop. The local reset pulse follows a stop, lasts one cycle and coincides with default outputs. The pointer decode cannot be seen by a property on its own, so the bench scenarios cover it: the option codes, the wrap from 0Fh to 00h, the exact-byte and check-bit guards on the mode byte, and read stepping. For these the bench compares every output on every clock against a behavioural model.

// File: rtl/led_regbank_pkg.sv
package led_regbank_pkg;
    // step option codes held in the pointer byte
    localparam logic [2:0] OPT_HOLD = 3'b000;
    localparam logic [2:0] OPT_STEP = 3'b001;
    // mode byte bit positions
    localparam int ALLCALL_BIT = 0;
    localparam int GUARD1_BIT  = 1;
    localparam int SLOW_BIT    = 4;
    localparam int GUARD0_BIT  = 6;
    localparam int LRST_BIT    = 7;
endpackage

// File: rtl/led_field_split.sv
module led_field_split #(
    parameter int DW    = 8,
    parameter int IDX_W = 5
) (
    input  logic [DW-1:0]       byte_i,
    output logic [DW-IDX_W-1:0] opt_o,
    output logic [IDX_W-1:0]    idx_o
);
    assign opt_o = byte_i[DW-1:IDX_W];
    assign idx_o = byte_i[IDX_W-1:0];
endmodule

// File: rtl/led_access_decode.sv
module led_access_decode
    import led_regbank_pkg::*;
#(
    parameter int NUM_CH   = 16,
    parameter int IDX_W    = 5,
    parameter int OPT_W    = 3,
    parameter int MODE_IDX = 26
) (
    input  logic [OPT_W-1:0] opt_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             bright_hit_o,
    output logic             step_o,
    output logic             mode_hit_o,
    output logic [IDX_W-1:0] next_idx_o
);
    localparam logic [IDX_W-1:0] MODE_V = IDX_W'(MODE_IDX);
    localparam logic [IDX_W-1:0] LAST_V = IDX_W'(NUM_CH - 1);

    logic opt_ok;

    always_comb begin
        opt_ok       = (opt_i == OPT_W'(OPT_HOLD)) || (opt_i == OPT_W'(OPT_STEP));
        bright_hit_o = opt_ok && (32'(idx_i) < NUM_CH);
        step_o       = (opt_i == OPT_W'(OPT_STEP));
        mode_hit_o   = (opt_i == OPT_W'(OPT_HOLD)) && (idx_i == MODE_V);
        next_idx_o   = (idx_i == LAST_V) ? '0 : idx_i + 1'b1;
    end
endmodule

// File: rtl/led_mode_guard.sv
module led_mode_guard
    import led_regbank_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data_i,
    output logic          accept_o
);
    assign accept_o = !data_i[GUARD0_BIT] && data_i[GUARD1_BIT];
endmodule

// File: rtl/led_regbank.sv
module led_regbank
    import led_regbank_pkg::*;
#(
    parameter int          NUM_CH   = 16,
    parameter int          DW       = 8,
    parameter int          IDX_W    = 5,
    parameter int          MODE_IDX = 26,
    parameter logic [7:0]  MODE_RST = 8'h03
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               wr_i,
    input  logic [DW-1:0]      wr_data_i,
    input  logic               rd_i,
    output logic [DW-1:0]      rd_data_o,
    output logic [NUM_CH*DW-1:0] bright_o,
    output logic               allcall_en_o,
    output logic               slow_pwm_o,
    output logic               local_rst_o
);
    localparam int OPT_W = DW - IDX_W;
    localparam int CH_W  = $clog2(NUM_CH);

    typedef struct packed {
        logic [NUM_CH-1:0][DW-1:0] bright;
        logic [DW-1:0]             mode;
        logic [DW-1:0]             pend;
        logic                      pend_v;
        logic [IDX_W-1:0]          idx;
        logic [OPT_W-1:0]          opt;
        logic                      first;
        logic                      lrst;
    } bank_t;

    localparam bank_t BANK_RST = '{
        bright: '0,
        mode:   DW'(MODE_RST),
        pend:   '0,
        pend_v: 1'b0,
        idx:    '0,
        opt:    '0,
        first:  1'b1,
        lrst:   1'b0
    };

    bank_t bank_d, bank_q;

    logic [OPT_W-1:0] in_opt;
    logic [IDX_W-1:0] in_idx;
    logic             bright_hit;
    logic             step;
    logic             mode_hit;
    logic [IDX_W-1:0] next_idx;
    logic             guard_ok;

    led_field_split #(.DW(DW), .IDX_W(IDX_W)) u_split (
        .byte_i (wr_data_i),
        .opt_o  (in_opt),
        .idx_o  (in_idx)
    );

    led_access_decode #(
        .NUM_CH(NUM_CH), .IDX_W(IDX_W), .OPT_W(OPT_W), .MODE_IDX(MODE_IDX)
    ) u_decode (
        .opt_i        (bank_q.opt),
        .idx_i        (bank_q.idx),
        .bright_hit_o (bright_hit),
        .step_o       (step),
        .mode_hit_o   (mode_hit),
        .next_idx_o   (next_idx)
    );

    led_mode_guard #(.DW(DW)) u_guard (
        .data_i   (wr_data_i),
        .accept_o (guard_ok)
    );

    always_comb begin
        bank_d      = bank_q;
        bank_d.lrst = 1'b0;

        if (wr_i) begin
            if (bank_q.first) begin
                bank_d.opt   = in_opt;
                bank_d.idx   = in_idx;
                bank_d.first = 1'b0;
            end else if (bright_hit) begin
                bank_d.bright[bank_q.idx[CH_W-1:0]] = wr_data_i;
                if (step) begin
                    bank_d.idx = next_idx;
                end
            end else if (mode_hit && guard_ok) begin
                bank_d.pend   = wr_data_i;
                bank_d.pend_v = 1'b1;
            end
        end

        if (rd_i && bright_hit && step) begin
            bank_d.idx = next_idx;
        end

        if (start_i) begin
            bank_d.first = 1'b1;
        end

        if (stop_i) begin
            bank_d.first = 1'b1;
            if (bank_q.pend_v) begin
                if (bank_q.pend[LRST_BIT]) begin
                    bank_d      = BANK_RST;
                    bank_d.lrst = 1'b1;
                end else begin
                    bank_d.mode   = bank_q.pend;
                    bank_d.pend_v = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= BANK_RST;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        if (bright_hit) begin
            rd_data_o = bank_q.bright[bank_q.idx[CH_W-1:0]];
        end else if (mode_hit) begin
            rd_data_o = bank_q.mode;
        end else begin
            rd_data_o = '0;
        end
    end

    assign bright_o     = bank_q.bright;
    assign allcall_en_o = bank_q.mode[ALLCALL_BIT];
    assign slow_pwm_o   = bank_q.mode[SLOW_BIT];
    assign local_rst_o  = bank_q.lrst;
endmodule

// File: rtl/led_regbank_chk.sv
module led_regbank_chk #(
    parameter int NUM_CH = 16,
    parameter int DW     = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_i,
    input logic                   stop_i,
    input logic [NUM_CH*DW-1:0]   bright_o,
    input logic                   allcall_en_o,
    input logic                   slow_pwm_o,
    input logic                   local_rst_o
);
    // duty values move only after a write strobe or a local reset
    assert_bright_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_i) && !local_rst_o) |-> $stable(bright_o));

    // mode outputs move only in the cycle after a stop
    assert_mode_at_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stop_i) |-> ($stable(allcall_en_o) && $stable(slow_pwm_o)));

    // local reset follows a stop
    assert_lrst_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        local_rst_o |-> $past(stop_i));

    // local reset lasts a single cycle
    assert_lrst_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        local_rst_o |=> !local_rst_o);

    // local reset brings defaults with it
    assert_lrst_defaults_R9: assert property (@(posedge clk) disable iff (!rst_n)
        local_rst_o |-> (allcall_en_o && !slow_pwm_o && (bright_o == '0)));
endmodule

bind led_regbank led_regbank_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (wr_i),
    .stop_i       (stop_i),
    .bright_o     (bright_o),
    .allcall_en_o (allcall_en_o),
    .slow_pwm_o   (slow_pwm_o),
    .local_rst_o  (local_rst_o)
);

// File: tb/led_regbank_tb.sv
`timescale 1ns/1ps
module led_regbank_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         stop_i = 1'b0;
    logic         wr_i = 1'b0;
    logic [7:0]   wr_data_i = 8'h00;
    logic         rd_i = 1'b0;
    logic [7:0]   rd_data_o;
    logic [127:0] bright_o;
    logic         allcall_en_o;
    logic         slow_pwm_o;
    logic         local_rst_o;

    int n_checks = 0;
    int n_fail = 0;
    string cur_req = "R5";
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;

    led_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .wr_i(wr_i), .wr_data_i(wr_data_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
        .bright_o(bright_o), .allcall_en_o(allcall_en_o),
        .slow_pwm_o(slow_pwm_o), .local_rst_o(local_rst_o)
    );

    // behavioural reference model
    int m_br[16];
    int m_mode, m_pend, m_idx, m_opt;
    bit m_pv, m_first, m_lr;

    task automatic model_reset();
        foreach (m_br[i]) m_br[i] = 0;
        m_mode = 8'h03; m_pend = 0; m_pv = 0;
        m_idx = 0; m_opt = 0; m_first = 1; m_lr = 0;
    endtask

    function automatic int model_rd();
        if ((m_opt == 0 || m_opt == 1) && m_idx < 16) return m_br[m_idx];
        if (m_opt == 0 && m_idx == 26) return m_mode;
        return 0;
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            m_lr = 0;
            if (wr_i) begin
                if (m_first) begin
                    m_opt = int'(wr_data_i) / 32;
                    m_idx = int'(wr_data_i) % 32;
                    m_first = 0;
                end else if ((m_opt == 0 || m_opt == 1) && m_idx < 16) begin
                    m_br[m_idx] = int'(wr_data_i);
                    if (m_opt == 1) m_idx = (m_idx + 1) % 16;
                end else if (m_opt == 0 && m_idx == 26 &&
                             wr_data_i[6] == 1'b0 && wr_data_i[1] == 1'b1) begin
                    m_pend = int'(wr_data_i);
                    m_pv = 1;
                end
            end
            if (rd_i && m_opt == 1 && m_idx < 16) m_idx = (m_idx + 1) % 16;
            if (start_i) m_first = 1;
            if (stop_i) begin
                m_first = 1;
                if (m_pv) begin
                    if (m_pend >= 128) begin
                        model_reset();
                        m_lr = 1;
                    end else begin
                        m_mode = m_pend;
                        m_pv = 0;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the edge
    always @(posedge clk) begin
        #5;
        if (cmp_on) begin
            for (int i = 0; i < 16; i++)
                check(cur_req, $sformatf("bright[%0d]", i), int'(bright_o[i*8 +: 8]), m_br[i]);
            check(cur_req, "allcall", int'(allcall_en_o), m_mode % 2);
            check(cur_req, "slow", int'(slow_pwm_o), (m_mode / 16) % 2);
            check(cur_req, "rd_data", int'(rd_data_o), model_rd());
            check(cur_req, "local_rst", int'(local_rst_o), int'(m_lr));
        end
    end

    task automatic do_start(); start_i = 1; @(negedge clk); start_i = 0; endtask
    task automatic do_stop();  stop_i = 1;  @(negedge clk); stop_i = 0;  endtask
    task automatic do_wr(input logic [7:0] b);
        wr_data_i = b; wr_i = 1; @(negedge clk); wr_i = 0;
    endtask
    task automatic do_rd(); rd_i = 1; @(negedge clk); rd_i = 0; endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;
        // R5 reset state
        check("R5", "reset bright", (bright_o == '0) ? 1 : 0, 1);
        check("R5", "reset allcall", int'(allcall_en_o), 1);
        check("R5", "reset slow", int'(slow_pwm_o), 0);

        // R1 and R2: fixed pointer, two writes to register 3
        cur_req = "R2";
        do_start(); do_wr(8'h03); do_wr(8'h55); do_wr(8'hAA); do_stop();
        check("R1", "bright[3]", int'(bright_o[31:24]), 8'hAA);
        check("R2", "bright[4] untouched", int'(bright_o[39:32]), 0);

        // R3: stepping with wrap
        cur_req = "R3";
        do_start(); do_wr(8'h2E); do_wr(8'h11); do_wr(8'h22); do_wr(8'h33); do_stop();
        check("R3", "bright[14]", int'(bright_o[119:112]), 8'h11);
        check("R3", "bright[15]", int'(bright_o[127:120]), 8'h22);
        check("R3", "bright[0] after wrap", int'(bright_o[7:0]), 8'h33);

        // R10: stepped reads
        cur_req = "R10";
        do_start(); do_wr(8'h2E); do_start();
        check("R10", "read 14", int'(rd_data_o), 8'h11);
        do_rd();
        check("R10", "read 15", int'(rd_data_o), 8'h22);
        do_rd();
        check("R10", "read 0 wrap", int'(rd_data_o), 8'h33);
        do_stop();

        // R4: prohibited option and unused index
        cur_req = "R4";
        do_start(); do_wr(8'h45); do_wr(8'h77); do_stop();
        check("R4", "bright[5] prohibited option", int'(bright_o[47:40]), 0);
        do_start(); do_wr(8'h10); do_wr(8'h77);
        check("R4", "read unused", int'(rd_data_o), 0);
        do_stop();
        check("R4", "bright[0] kept", int'(bright_o[7:0]), 8'h33);

        // R6: mode index with step option is not a mode write
        cur_req = "R6";
        do_start(); do_wr(8'h3A); do_wr(8'h12); do_stop();
        check("R6", "slow after 3Ah", int'(slow_pwm_o), 0);
        check("R6", "allcall after 3Ah", int'(allcall_en_o), 1);

        // R7: check bits wrong
        cur_req = "R7";
        do_start(); do_wr(8'h1A); do_wr(8'h52); do_stop();
        check("R7", "bit6 set rejected", int'(slow_pwm_o), 0);
        do_start(); do_wr(8'h1A); do_wr(8'h10); do_stop();
        check("R7", "bit1 clear rejected", int'(slow_pwm_o), 0);

        // R8: mode takes effect at the stop
        cur_req = "R8";
        do_start(); do_wr(8'h1A); do_wr(8'h12);
        check("R8", "slow before stop", int'(slow_pwm_o), 0);
        check("R8", "allcall before stop", int'(allcall_en_o), 1);
        do_stop();
        check("R8", "slow after stop", int'(slow_pwm_o), 1);
        check("R8", "allcall after stop", int'(allcall_en_o), 0);
        do_start(); do_wr(8'h1A); do_start();
        check("R8", "mode readback", int'(rd_data_o), 8'h12);
        do_stop();

        // R9: local reset through the mode byte
        cur_req = "R9";
        do_start(); do_wr(8'h1A); do_wr(8'h82);
        stop_i = 1; @(negedge clk); stop_i = 0;
        check("R9", "local_rst pulse", int'(local_rst_o), 1);
        check("R9", "bright cleared", (bright_o == '0) ? 1 : 0, 1);
        check("R9", "allcall restored", int'(allcall_en_o), 1);
        check("R9", "slow restored", int'(slow_pwm_o), 0);
        @(negedge clk);
        check("R9", "local_rst ends", int'(local_rst_o), 0);

        repeat (2) @(negedge clk);
        cmp_on = 0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule